// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Deferred Settings Commit

This block drives one pulse-width-modulated output from a single 32-bit control word on a simple memory-mapped write/read port. The output frequency comes from a fractional phase accumulator of N+8 bits. On every clock of a running channel, the accumulator adds a programmable increment (the step field, N bits wide). The duty cycle comes from an 8-bit inverted threshold, which is compared with the top byte of the accumulator.

Software writes new settings into a shadow copy and sets a commit-request flag. The channel copies the shadow step and threshold into its active copy only at the start of the next output cycle, and at that moment hardware clears the flag. Software polls the flag until it reads zero before it writes the next configuration. Several channels can share one address space: each instance decodes its own word at a multiple of 0x400 given by a parameter. The whole word can be read back, so software can save and restore the channel.

Top module: `pwmacc_channel`

## Requirements
- R1: The control word has this layout: bit 31 is run enable, bit 30 is commit request, bits [8+N-1:8] are the step and bits [7:0] are the threshold. A read returns the enable, step and threshold last written, the current commit-request flag, and zero in every other bit.
- R2: The word sits at byte address CH_INDEX*0x400. A write to any other address changes nothing. A read from any other address returns zero.
- R3: While running, the accumulator advances by the active step on every clock and wraps modulo 2^(N+8). The output period is therefore 2^(N+8)/step clocks when the step divides that value.
- R4: The output is high while the accumulator's top byte is greater than or equal to the active threshold, so the high time per period is (256-threshold)*2^N/step clocks. A threshold of 255 keeps the output low at all times, and a threshold of 0 keeps it high at all times.
- R5: A matching write with bit 30 set makes bit 30 read as 1 until the commit takes place.
- R6: Active settings change only at a cycle start, which is the wrap of the accumulator or the first clock after enabling. At that cycle start the pending shadow values are loaded and bit 30 is cleared. A mid-cycle write has no effect on the waveform before the next boundary.
- R7: A write that arrives while a commit is pending updates only the shadow. Writing bit 30 as 0 at that time does not cancel the pending commit.
- R8: While the enable is 0, the output is low and the accumulator is held at zero, and a pending commit waits. On enabling, a cycle starts from phase zero and any pending commit is applied at that cycle start.
- R9: After reset the whole control word reads zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one clock per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the channel with a 4-bit step and channel index 1. This gives a 12-bit accumulator and places the word at 0x400, and it makes address 0x000 a real miss. With steps that are powers of two, every period (512 to 4096 clocks) and every high time is an exact integer, so it can be measured clock for clock. Short periods also let one run cover the commit at enable, a mid-cycle change taking effect at the boundary, both threshold extremes, and a restart from phase zero.

// File: rtl/pwmacc_pkg.sv
package pwmacc_pkg;
    localparam int          EN_BIT    = 31;
    localparam int          REQ_BIT   = 30;
    localparam int          STEP_LSB  = 8;
    localparam int          THR_W     = 8;
    localparam int          CH_STRIDE = 32'h400;
    localparam logic [7:0]  THR_NEVER = 8'hFF;
endpackage

// File: rtl/pwmacc_regs.sv
module pwmacc_regs
    import pwmacc_pkg::*;
#(
    parameter int BU_W     = 8,
    parameter int ADDR_W   = 12,
    parameter int CH_INDEX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              commit,
    output logic              en_o,
    output logic              req_o,
    output logic [BU_W-1:0]   step_o,
    output logic [7:0]        thr_o,
    output logic [31:0]       rd_data
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CH_INDEX * CH_STRIDE);

    typedef struct packed {
        logic            en;
        logic            req;
        logic [BU_W-1:0] step;
        logic [7:0]      thr;
    } shadow_t;

    shadow_t shd_q, shd_d;
    logic    hit;
    logic    wr_hit;
    logic    unused_bits;

    assign unused_bits = ^wr_data[REQ_BIT-1:STEP_LSB+BU_W];

    always_comb begin
        hit    = (addr == MY_ADDR);
        wr_hit = wr_en && hit;
        shd_d  = shd_q;
        if (commit) begin
            shd_d.req = 1'b0;
        end
        if (wr_hit) begin
            shd_d.en   = wr_data[EN_BIT];
            shd_d.step = wr_data[STEP_LSB +: BU_W];
            shd_d.thr  = wr_data[THR_W-1:0];
            if (wr_data[REQ_BIT]) begin
                shd_d.req = 1'b1;
            end
        end
        rd_data = '0;
        if (hit) begin
            rd_data[EN_BIT]              = shd_q.en;
            rd_data[REQ_BIT]             = shd_q.req;
            rd_data[STEP_LSB +: BU_W]    = shd_q.step;
            rd_data[THR_W-1:0]           = shd_q.thr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign en_o   = shd_q.en;
    assign req_o  = shd_q.req;
    assign step_o = shd_q.step;
    assign thr_o  = shd_q.thr;

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        shd_q.req && !commit |=> shd_q.req); // R7

    AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr != MY_ADDR) && !commit |=> $stable(shd_q)); // R2

    AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !(wr_hit && wr_data[REQ_BIT]) |=> !shd_q.req); // R6
endmodule

// File: rtl/pwmacc_phase.sv
module pwmacc_phase #(
    parameter int BU_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            pend,
    input  logic [BU_W-1:0] step_shd,
    input  logic [7:0]      thr_shd,
    output logic            commit,
    output logic            run,
    output logic [7:0]      top,
    output logic [7:0]      thr_act
);
    localparam int ACC_W = BU_W + 8;

    typedef struct packed {
        logic             run;
        logic [ACC_W-1:0] acc;
        logic [BU_W-1:0]  step;
        logic [7:0]       thr;
    } phase_t;

    phase_t         ph_q, ph_d;
    logic [ACC_W:0] sum;
    logic           start;

    always_comb begin
        ph_d  = ph_q;
        sum   = {1'b0, ph_q.acc} + (ACC_W + 1)'(ph_q.step);
        start = 1'b0;
        if (!en) begin
            ph_d.run = 1'b0;
            ph_d.acc = '0;
        end else if (!ph_q.run) begin
            ph_d.run = 1'b1;
            ph_d.acc = '0;
            start    = 1'b1;
        end else begin
            ph_d.acc = sum[ACC_W-1:0];
            start    = sum[ACC_W];
        end
        commit = start && pend;
        if (commit) begin
            ph_d.step = step_shd;
            ph_d.thr  = thr_shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign run     = ph_q.run;
    assign top     = ph_q.acc[ACC_W-1 -: 8];
    assign thr_act = ph_q.thr;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ph_q.acc == '0) && !ph_q.run); // R8

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ph_q.step) && $stable(ph_q.thr)); // R6

    AST_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_q.run) |-> (ph_q.acc == '0)); // R8
endmodule

// File: rtl/pwmacc_cmp.sv
module pwmacc_cmp
    import pwmacc_pkg::*;
(
    input  logic       run,
    input  logic [7:0] top,
    input  logic [7:0] thr,
    output logic       out
);
    always_comb begin
        out = run && (thr != THR_NEVER) && (top >= thr);
    end
endmodule

// File: rtl/pwmacc_channel.sv
module pwmacc_channel
    import pwmacc_pkg::*;
#(
    parameter int BU_W     = 8,
    parameter int ADDR_W   = 12,
    parameter int CH_INDEX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    output logic [31:0]       bus_rd_data,
    output logic              pwm_out
);
    logic            en_shd;
    logic            req_shd;
    logic [BU_W-1:0] step_shd;
    logic [7:0]      thr_shd;
    logic            commit;
    logic            run;
    logic [7:0]      top;
    logic [7:0]      thr_act;

    pwmacc_regs #(.BU_W(BU_W), .ADDR_W(ADDR_W), .CH_INDEX(CH_INDEX)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .commit  (commit),
        .en_o    (en_shd),
        .req_o   (req_shd),
        .step_o  (step_shd),
        .thr_o   (thr_shd),
        .rd_data (bus_rd_data)
    );

    pwmacc_phase #(.BU_W(BU_W)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_shd),
        .pend     (req_shd),
        .step_shd (step_shd),
        .thr_shd  (thr_shd),
        .commit   (commit),
        .run      (run),
        .top      (top),
        .thr_act  (thr_act)
    );

    pwmacc_cmp cmp_i (
        .run (run),
        .top (top),
        .thr (thr_act),
        .out (pwm_out)
    );

    AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out); // R8

    AST_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_act == THR_NEVER) |-> !pwm_out); // R4

    AST_ALWAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        run && (thr_act == 8'h00) |-> pwm_out); // R4
endmodule

// File: tb/pwmacc_channel_tb_top.sv
module pwmacc_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BU_W       = 4;
    localparam int ADDR_W     = 12;
    localparam logic [ADDR_W-1:0] MY_A = 12'h400;

    typedef struct packed {
        logic [3:0] step;
        logic [7:0] thr;
        int         per;
        int         hi;
    } vec_t;

    // period = 4096/step, high = (256-thr)*16/step
    localparam vec_t VECS [6] = '{
        '{4'd8, 8'd128,  512,  256},
        '{4'd4, 8'd64,  1024,  768},
        '{4'd8, 8'd200,  512,  112},
        '{4'd2, 8'd250, 2048,   48},
        '{4'd8, 8'd1,    512,  510},
        '{4'd1, 8'd192, 4096, 1024}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = MY_A;
    logic              bus_wr_en = 1'b0;
    logic [31:0]       bus_wr_data = '0;
    logic [31:0]       bus_rd_data;
    logic              pwm_out;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwmacc_channel #(.BU_W(BU_W), .ADDR_W(ADDR_W), .CH_INDEX(1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .pwm_out     (pwm_out)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_en = 1'b1; bus_wr_data = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = MY_A;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rd_data;
        bus_addr = MY_A;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] d;
        int i;
        for (i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd(MY_A, d);
            if (!d[30]) break;
        end
        chk(i < 20000, 1, tag);
    endtask

    task automatic wait_level(input logic lvl);
        for (int i = 0; i < 10000; i++) begin
            if (pwm_out == lvl) break;
            @(negedge clk);
        end
    endtask

    task automatic measure(output int per, output int hi);
        logic last;
        wait_level(1'b0);
        wait_level(1'b1);
        per = 0; hi = 0;
        for (int i = 0; i < 10000; i++) begin
            if (pwm_out) hi++;
            per++;
            last = pwm_out;
            @(negedge clk);
            if (pwm_out && !last) break;
        end
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int per, hi, t0, t1, t2, t3;

        repeat (3) @(negedge clk);
        rd(MY_A, d);
        chk(d, 32'h0, "R9 reset word");
        chk(pwm_out, 0, "R9 reset output");
        rst_n = 1'b1;

        // R1: full-word write while disabled, unused bits read zero
        wr(MY_A, 32'h7FFF_FFFF);
        rd(MY_A, d);
        chk(d, 32'h4000_0FFF, "R1 readback layout");
        chk(d[30], 1, "R5 request flag set");
        count_high(50, hi);
        chk(hi, 0, "R8 disabled output low, commit waits");

        // R2: address miss
        wr(12'h000, 32'h8000_0000);
        rd(MY_A, d);
        chk(d, 32'h4000_0FFF, "R2 miss write ignored");
        rd(12'h000, d);
        chk(d, 32'h0, "R2 miss read zero");

        // R7: writes while pending
        wr(MY_A, 32'h4000_0880);
        rd(MY_A, d);
        chk(d, 32'h4000_0880, "R7 shadow updated while pending");
        wr(MY_A, 32'h0000_0880);
        rd(MY_A, d);
        chk(d, 32'h4000_0880, "R7 pending not cancelled");

        // R8: enable applies pending commit at phase zero
        wr(MY_A, 32'h8000_0880);
        t0 = int'(cyc);
        wait_level(1'b1);
        chk(int'(cyc) - t0, 257, "R8 first rise after enable");
        rd(MY_A, d);
        chk(d, 32'h8000_0880, "R6 flag cleared at enable start");

        // R3/R4: vector table
        foreach (VECS[k]) begin
            wr(MY_A, {2'b11, 18'd0, VECS[k].step, VECS[k].thr});
            wait_idle("R6 commit completes");
            measure(per, hi);
            chk(per, VECS[k].per, $sformatf("R3 period vec%0d", k));
            chk(hi, VECS[k].hi, $sformatf("R4 high time vec%0d", k));
        end

        // R6: mid-cycle change applies at next boundary
        wr(MY_A, 32'hC000_0880);
        wait_idle("R6 commit base config");
        wait_level(1'b1);
        wait_level(1'b0);
        t0 = int'(cyc);
        repeat (10) @(negedge clk);
        wr(MY_A, 32'hC000_0820);
        rd(MY_A, d);
        chk(d[30], 1, "R6 flag pending mid-cycle");
        wait_level(1'b1);
        t1 = int'(cyc);
        chk(t1 - t0, 256, "R6 old threshold kept this cycle");
        wait_level(1'b0);
        t2 = int'(cyc);
        chk(t2 - t0, 512, "R3 boundary at 512");
        rd(MY_A, d);
        chk(d[30], 0, "R6 flag cleared at boundary");
        wait_level(1'b1);
        t3 = int'(cyc);
        chk(t3 - t2, 64, "R6 new threshold from boundary");

        // R4 extremes
        wr(MY_A, 32'hC000_08FF);
        wait_idle("R4 commit 255");
        count_high(600, hi);
        chk(hi, 0, "R4 threshold 255 never high");
        wr(MY_A, 32'hC000_0800);
        wait_idle("R4 commit 0");
        count_high(600, hi);
        chk(hi, 600, "R4 threshold 0 always high");

        // R8: disable and restart from phase zero
        wr(MY_A, 32'hC000_0880);
        wait_idle("R8 commit before disable");
        wr(MY_A, 32'h0000_0880);
        @(negedge clk);
        count_high(600, hi);
        chk(hi, 0, "R8 disabled output low");
        wr(MY_A, 32'h8000_0880);
        t0 = int'(cyc);
        wait_level(1'b1);
        chk(int'(cyc) - t0, 257, "R8 restart from phase zero");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule